// File: doc/BRIEF.md
# Host Receive Status Flags

This block carries data words from a processor core to an external host and reports the state of that path through an 8-bit status register. The core writes a 16-bit word into a transmit holding register. When the host-side receive bytes are free, the word moves into a pair of host-readable byte registers, one for the high byte and one for the low byte. A receive-full flag then tells the host that a word is waiting.

The host reads the two bytes and then reads the status register. An endianness control selects which of the two byte reads completes the transfer and clears the receive-full flag. A separate initialize pulse also clears the flag. An active-low request output pulls the host's attention while a word is waiting, but only when the receive-request enable is set.

The status register also carries two host flags driven from the core side and two readiness flags from the opposite direction's path. The block samples all four each cycle. The status register is read-only: any host write cycle leaves the block unchanged.

Top module: `hrx_status_top`

## Requirements
- R1: After reset the status register reads 0x06, `host_req_n` is high and `core_tx_full` is low.
- R2: Status register layout, as read at host address 0:
  - bit 0: receive-full
  - bit 1: transmit-empty
  - bit 2: transmitter-ready
  - bit 3: host flag 2
  - bit 4: host flag 3
  - bit 7: request asserted
  - bits 5 and 6: always 0

  Host address 1 returns the high receive byte, address 2 the low receive byte, and address 3 reads 0.
- R3: A host cycle with `host_wr` high, whether or not `host_rd` is also high, changes no state. This holds for a write to the status address and for a write to the byte addresses.
- R4: A core write is accepted when `core_tx_full` is low. `core_tx_full` rises after the next clock edge. If receive-full is clear, the word moves into the receive bytes on the following edge: bits 15:8 go to the high byte and bits 7:0 to the low byte. That same edge sets receive-full and drops `core_tx_full`.
- R5: With `last_byte_low` = 1, a host read of address 2 clears receive-full on that clock edge. With `last_byte_low` = 0, a read of address 1 does so. A read of the other byte leaves receive-full set.
- R6: A `host_init` pulse clears receive-full on that clock edge.
- R7: `host_req_n` is low exactly when `rreq_en` is 1 and receive-full is set. Status bit 7 is 1 exactly in that case.
- R8: A word accepted while receive-full is set waits in the transmit register. It moves into the receive bytes on the edge after the one that clears receive-full.
- R9: A core write while `core_tx_full` is high is dropped. The waiting word is kept.
- R10: `hf2_in`, `hf3_in`, `h2c_empty_in` and `h2c_ready_in` are sampled every clock edge into status bits 3, 4, 1 and 2. Each bit shows its input one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr | input | 1 | Core write strobe for the transmit word |
| core_word | input | 16 | Transmit word from the core |
| core_tx_full | output | 1 | Transmit register holds a word not yet moved |
| hf2_in | input | 1 | Host flag 2 from the core control register |
| hf3_in | input | 1 | Host flag 3 from the core control register |
| h2c_empty_in | input | 1 | Transmit-empty state from the host-to-core path |
| h2c_ready_in | input | 1 | Transmitter-ready state from the host-to-core path |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (no effect on state) |
| host_addr | input | 2 | Host register select: 0 status, 1 high byte, 2 low byte |
| host_rdata | output | 8 | Read data for the selected register |
| last_byte_low | input | 1 | 1: low-byte read completes a transfer; 0: high-byte read does |
| host_init | input | 1 | Initialize pulse that clears receive-full |
| rreq_en | input | 1 | Receive-request enable for the request output |
| host_req_n | output | 1 | Active-low host request |

## Verification
A receive-full flag stuck high or low shows at the ports within one cycle. It appears in status bit 0 and in `host_req_n`, and it breaks the clearing order selected by the endianness control. A transfer that is lost, doubled or taken from the wrong register shows at the next drain of a word. There the two byte reads no longer match the word the driver queued. A dropped write that is wrongly accepted also shows up: receive-full rises again after the queue is empty.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    typedef enum logic [1:0] {
        HA_STAT = 2'd0,
        HA_RXH  = 2'd1,
        HA_RXL  = 2'd2,
        HA_NONE = 2'd3
    } host_addr_e;

    localparam int unsigned STAT_W    = 8;
    localparam int unsigned STAT_RXF  = 0;
    localparam int unsigned STAT_TXE  = 1;
    localparam int unsigned STAT_TRDY = 2;
    localparam int unsigned STAT_HF2  = 3;
    localparam int unsigned STAT_HF3  = 4;
    localparam int unsigned STAT_REQ  = 7;

    localparam logic [STAT_W-1:0] STAT_RST = 8'h06;

endpackage

// File: rtl/hrx_xfer.sv
module hrx_xfer
    import hrx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_wr,
    input  logic [2*BYTE_W-1:0] core_word,
    input  logic                rd_acc,
    input  host_addr_e          rd_addr,
    input  logic                last_low,
    input  logic                init,
    output logic [BYTE_W-1:0]   rx_hi,
    output logic [BYTE_W-1:0]   rx_lo,
    output logic                rx_full,
    output logic                tx_full
);

    localparam int unsigned WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] txw;
        logic              txf;
        logic [BYTE_W-1:0] rxh;
        logic [BYTE_W-1:0] rxl;
        logic              rxf;
    } xfer_st_t;

    xfer_st_t   st_d, st_q;
    logic       go;
    logic       done_hit;
    host_addr_e done_addr;

    always_comb begin
        st_d      = st_q;
        go        = st_q.txf & ~st_q.rxf;
        done_addr = last_low ? HA_RXL : HA_RXH;
        done_hit  = rd_acc & (rd_addr == done_addr) & st_q.rxf;

        if (go) begin
            st_d.rxh = st_q.txw[WORD_W-1:BYTE_W];
            st_d.rxl = st_q.txw[BYTE_W-1:0];
            st_d.txf = 1'b0;
            st_d.rxf = 1'b1;
        end else if (done_hit || init) begin
            st_d.rxf = 1'b0;
        end

        if (core_wr && !st_q.txf) begin
            st_d.txw = core_word;
            st_d.txf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_hi   = st_q.rxh;
    assign rx_lo   = st_q.rxl;
    assign rx_full = st_q.rxf;
    assign tx_full = st_q.txf;

    // R8
    xfer_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.txf && !st_q.rxf) |=> (st_q.rxf && !st_q.txf));

    // R4
    xfer_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rxf) |-> ($past(st_q.txf) &&
                             {st_q.rxh, st_q.rxl} == $past(st_q.txw)));

    // R6
    init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rxf && init) |=> !st_q.rxf);

    // R5
    read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rxf && rd_acc && rd_addr == (last_low ? HA_RXL : HA_RXH)) |=> !st_q.rxf);

    // R5
    read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rxf && !init && rd_acc &&
         rd_addr == (last_low ? HA_RXH : HA_RXL)) |=> st_q.rxf);

    // R9
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.txf && st_q.rxf) |=> $stable(st_q.txw));

endmodule

// File: rtl/hrx_flags.sv
module hrx_flags
    import hrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hf2_in,
    input  logic              hf3_in,
    input  logic              txe_in,
    input  logic              trdy_in,
    input  logic              rx_full,
    input  logic              rreq_en,
    output logic [STAT_W-1:0] stat,
    output logic              req_n
);

    typedef struct packed {
        logic hf2;
        logic hf3;
        logic txe;
        logic trdy;
    } flag_st_t;

    flag_st_t fl_d, fl_q;
    logic     req;

    always_comb begin
        fl_d.hf2  = hf2_in;
        fl_d.hf3  = hf3_in;
        fl_d.txe  = txe_in;
        fl_d.trdy = trdy_in;

        req = rreq_en & rx_full;

        stat            = '0;
        stat[STAT_RXF]  = rx_full;
        stat[STAT_TXE]  = fl_q.txe;
        stat[STAT_TRDY] = fl_q.trdy;
        stat[STAT_HF2]  = fl_q.hf2;
        stat[STAT_HF3]  = fl_q.hf3;
        stat[STAT_REQ]  = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q.hf2  <= STAT_RST[STAT_HF2];
            fl_q.hf3  <= STAT_RST[STAT_HF3];
            fl_q.txe  <= STAT_RST[STAT_TXE];
            fl_q.trdy <= STAT_RST[STAT_TRDY];
        end else begin
            fl_q <= fl_d;
        end
    end

    assign req_n = ~req;

    // R10
    hf_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat[STAT_HF3] == $past(hf3_in) && stat[STAT_HF2] == $past(hf2_in)));

    // R7
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && rreq_en) |-> !req_n);

endmodule

// File: rtl/hrx_status_top.sv
module hrx_status_top
    import hrx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_wr,
    input  logic [2*BYTE_W-1:0] core_word,
    output logic                core_tx_full,
    input  logic                hf2_in,
    input  logic                hf3_in,
    input  logic                h2c_empty_in,
    input  logic                h2c_ready_in,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [1:0]          host_addr,
    output logic [BYTE_W-1:0]   host_rdata,
    input  logic                last_byte_low,
    input  logic                host_init,
    input  logic                rreq_en,
    output logic                host_req_n
);

    host_addr_e        addr;
    logic              rd_acc;
    logic [BYTE_W-1:0] rx_hi, rx_lo;
    logic              rx_full;
    logic [STAT_W-1:0] stat;

    assign addr   = host_addr_e'(host_addr);
    assign rd_acc = host_rd & ~host_wr;

    hrx_xfer #(.BYTE_W(BYTE_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_wr   (core_wr),
        .core_word (core_word),
        .rd_acc    (rd_acc),
        .rd_addr   (addr),
        .last_low  (last_byte_low),
        .init      (host_init),
        .rx_hi     (rx_hi),
        .rx_lo     (rx_lo),
        .rx_full   (rx_full),
        .tx_full   (core_tx_full)
    );

    hrx_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hf2_in  (hf2_in),
        .hf3_in  (hf3_in),
        .txe_in  (h2c_empty_in),
        .trdy_in (h2c_ready_in),
        .rx_full (rx_full),
        .rreq_en (rreq_en),
        .stat    (stat),
        .req_n   (host_req_n)
    );

    always_comb begin
        case (addr)
            HA_STAT: host_rdata = BYTE_W'(stat);
            HA_RXH:  host_rdata = rx_hi;
            HA_RXL:  host_rdata = rx_lo;
            default: host_rdata = '0;
        endcase
    end

    // R3
    wr_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_init && rx_full) |=> rx_full);

endmodule

// File: tb/hrx_status_top_test.sv
module hrx_status_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_wr = 1'b0;
    logic [15:0] core_word = '0;
    logic        core_tx_full;
    logic        hf2_in = 1'b0, hf3_in = 1'b0;
    logic        h2c_empty_in = 1'b1, h2c_ready_in = 1'b1;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd3;
    logic [7:0]  host_rdata;
    logic        last_byte_low = 1'b1;
    logic        host_init = 1'b0;
    logic        rreq_en = 1'b0;
    logic        host_req_n;

    int checks = 0;
    int fails  = 0;
    logic [15:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hrx_status_top uut (
        .clk(clk), .rst_n(rst_n), .core_wr(core_wr), .core_word(core_word),
        .core_tx_full(core_tx_full), .hf2_in(hf2_in), .hf3_in(hf3_in),
        .h2c_empty_in(h2c_empty_in), .h2c_ready_in(h2c_ready_in),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_rdata(host_rdata), .last_byte_low(last_byte_low),
        .host_init(host_init), .rreq_en(rreq_en), .host_req_n(host_req_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        host_rd   = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd   = 1'b0;
        host_addr = 2'd3;
    endtask

    // driver: queue the word when it is expected to reach the host
    task automatic send(input logic [15:0] w, input bit expect_taken);
        core_wr   = 1'b1;
        core_word = w;
        @(negedge clk);
        core_wr   = 1'b0;
        if (expect_taken) expq.push_back(w);
    endtask

    // monitor: pop the expected word and read it out through the host side
    task automatic drain();
        logic [7:0]  s, b1, b2;
        logic [15:0] got, want;
        logic [1:0]  first, last;
        if (expq.size() == 0) begin
            chk("R4 scoreboard empty", 32'd1, 32'd0);
            return;
        end
        want  = expq.pop_front();
        first = last_byte_low ? 2'd1 : 2'd2;
        last  = last_byte_low ? 2'd2 : 2'd1;
        peek(2'd0, s);
        chk("R4 rx-full set before read", 32'(s[0]), 32'd1);
        hread(first, b1);
        peek(2'd0, s);
        chk("R5 other byte keeps rx-full", 32'(s[0]), 32'd1);
        hread(last, b2);
        peek(2'd0, s);
        chk("R5 completing byte clears rx-full", 32'(s[0]), 32'd0);
        got = last_byte_low ? {b1, b2} : {b2, b1};
        chk("R4 word bytes", 32'(got), 32'(want));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        peek(2'd0, s);
        chk("R1 status reset", 32'(s), 32'h06);
        chk("R1 req_n reset", 32'(host_req_n), 32'd1);
        chk("R1 tx_full reset", 32'(core_tx_full), 32'd0);
        peek(2'd3, s);
        chk("R2 unused address reads 0", 32'(s), 32'd0);

        // A: low byte completes, request gated
        send(16'hA55A, 1);
        chk("R4 tx_full after write", 32'(core_tx_full), 32'd1);
        step();
        peek(2'd0, s);
        chk("R4 rx-full after transfer", 32'(s[0]), 32'd1);
        chk("R4 tx_full dropped", 32'(core_tx_full), 32'd0);
        chk("R7 req_n high with enable off", 32'(host_req_n), 32'd1);
        rreq_en = 1'b1;
        peek(2'd0, s);
        chk("R7 req_n low with enable on", 32'(host_req_n), 32'd0);
        chk("R7 status bit 7", 32'(s[7]), 32'd1);
        drain();
        chk("R7 req_n released", 32'(host_req_n), 32'd1);

        // B: high byte completes
        last_byte_low = 1'b0;
        send(16'h1234, 1);
        step();
        drain();

        // C: initialize
        send(16'hBEEF, 0);
        step();
        peek(2'd0, s);
        chk("R6 rx-full before init", 32'(s[0]), 32'd1);
        host_init = 1'b1;
        step();
        host_init = 1'b0;
        peek(2'd0, s);
        chk("R6 init clears rx-full", 32'(s[0]), 32'd0);
        chk("R6 req_n after init", 32'(host_req_n), 32'd1);

        // D: pending word and dropped write
        last_byte_low = 1'b1;
        send(16'h1111, 1);
        step();
        send(16'h2222, 1);
        peek(2'd0, s);
        chk("R8 second word waits", 32'(core_tx_full), 32'd1);
        chk("R8 rx-full held", 32'(s[0]), 32'd1);
        send(16'h3333, 0);
        chk("R9 tx_full still set", 32'(core_tx_full), 32'd1);
        drain();
        chk("R8 waiting word not yet moved", 32'(core_tx_full), 32'd1);
        step();
        peek(2'd0, s);
        chk("R8 waiting word moved", 32'(s[0]), 32'd1);
        chk("R8 tx_full cleared", 32'(core_tx_full), 32'd0);
        drain();
        step();
        peek(2'd0, s);
        chk("R9 dropped word never arrives", 32'(s[0]), 32'd0);
        chk("R9 tx register empty", 32'(core_tx_full), 32'd0);

        // E: host writes have no effect
        send(16'hCAFE, 1);
        step();
        host_wr = 1'b1;
        host_addr = 2'd0;
        step();
        host_rd = 1'b1;
        host_addr = 2'd2;
        step();
        host_rd = 1'b0;
        host_wr = 1'b0;
        peek(2'd0, s);
        chk("R3 status unchanged by writes", 32'(s), 32'h87);
        drain();

        // F: sampled flags and layout
        hf2_in = 1'b1; hf3_in = 1'b0; h2c_empty_in = 1'b0; h2c_ready_in = 1'b1;
        peek(2'd0, s);
        chk("R10 flags not yet sampled", 32'(s), 32'h06);
        step();
        peek(2'd0, s);
        chk("R10 flags sampled set 1", 32'(s), 32'h0C);
        hf2_in = 1'b0; hf3_in = 1'b1; h2c_empty_in = 1'b1; h2c_ready_in = 1'b0;
        step();
        peek(2'd0, s);
        chk("R2 layout with reserved bits 0", 32'(s), 32'h12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule